// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Address Filtering

This block is the receive half of an asynchronous serial port for a small controller. A baud generator outside the block supplies a single-cycle tick at sixteen times the bit rate. The block watches the line for a start edge, times each bit with those ticks, and decides each bit by a vote of three samples taken near the middle of the bit. It then hands software a byte, one extra status bit, and a receive flag that stays set until software clears it.

Two frame lengths are offered. The short frame carries eight data bits and a stop bit. The long frame carries eight data bits, a ninth bit and a stop bit. The extra status bit holds the ninth bit of a long frame, or the stop bit of a short one. With the address filter switched on, a node on a shared line is woken only by long frames whose ninth bit is 1, which mark address frames, and not by data frames. In the short format the same switch rejects frames whose stop bit was sampled low.

Top module: `serial_rx9`

## Requirements
- R1: `modeSel` selects the frame: 2'b01 gives the short frame (start, 8 data, stop), 2'b10 and 2'b11 both give the long frame (start, 8 data, ninth, stop), and 2'b00 starts no reception at all, so the outputs never change in that setting.
- R2: Data bits arrive least significant bit first, and an accepted frame presents its eight data bits on `rxData`, with the first bit received at bit 0.
- R3: On an accepted frame, `bit9Flag` takes the ninth bit in the long format and the sampled stop bit in the short format.
- R4: With `multiDrop` = 0, every completed frame is accepted while `rxFlag` is 0. This includes a long frame whose ninth bit is 0 and a short frame whose stop bit is low. Acceptance sets `rxFlag`.
- R5: With `multiDrop` = 1, a long frame whose ninth bit is 0 is dropped: `rxFlag`, `rxData` and `bit9Flag` keep their values.
- R6: With `multiDrop` = 1, a short frame whose stop bit is sampled low is dropped in the same way.
- R7: While `rxEnable` is 0, a falling edge on `rxPin` starts no reception, and the outputs do not change.
- R8: A start bit whose vote at mid-bit comes out high is treated as a false start. Reception aborts without changing any output, and a later frame is received normally.
- R9: Each bit is the majority of three samples taken at oversample ticks 7, 8 and 9 of the bit, where tick 0 is the first tick after the start edge. A single wrong sample does not change the bit, and two wrong samples do.
- R10: While `rxFlag` is 1, a further frame is discarded, and `rxData` and `bit9Flag` hold the earlier frame.
- R11: A one-cycle pulse on `rxFlagClear` clears `rxFlag` on the next clock edge.
- R12: After reset, `rxFlag`, `bit9Flag` and `rxData` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 2 | Frame-format select |
| multiDrop | input | 1 | Address-filter enable |
| rxEnable | input | 1 | Allows new receptions to start |
| baudTick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxPin | input | 1 | Serial line, idle high |
| rxFlagClear | input | 1 | Software clear pulse for rxFlag |
| rxData | output | 8 | Last accepted data byte |
| bit9Flag | output | 1 | Ninth bit (long frame) or stop bit (short frame) |
| rxFlag | output | 1 | Frame-received flag |

## Verification
Reception is decided at tick 9 of the stop bit. The data byte, the extra status bit and the flag are all loaded on that clock edge. A clear pulse takes effect on the edge that samples it. The bench sends every bit as sixteen ticks spaced eight clocks apart and changes the line seven clocks before the tick it is aimed at, which covers the two-flop synchronizer delay. It samples the outputs only after the whole stop bit and two idle ticks have gone by, well after the results are due, and never in the cycle a load can happen. Glitch and false-start stimuli are placed on exact tick numbers, so the three sample points of the vote are hit on purpose.

// File: rtl/serial_rx9_pkg.sv
`timescale 1ns/1ps
package serial_rx9_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic takeFirst;   // capture first vote sample
    logic takeSecond;  // capture second vote sample
    logic shiftBit;    // push voted bit into the shift register
    logic finish;      // stop bit decided: frame complete
    logic frameNine;   // current frame is the long format
  } rxStrobes_t;

endpackage

// File: rtl/serial_rx9_ctrl.sv
`timescale 1ns/1ps
module serial_rx9_ctrl
  import serial_rx9_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       rxEnable,
  input  logic       baudTick,
  input  logic       fallEdge,
  input  logic       vote,
  output rxStrobes_t strb
);

  localparam int CNT_W     = $clog2(OVERSAMPLE);
  localparam int MID       = OVERSAMPLE / 2;
  localparam int FIRST_AT  = MID - 1;
  localparam int SECOND_AT = MID;
  localparam int DECIDE_AT = MID + 1;
  localparam int LAST_AT   = OVERSAMPLE - 1;
  localparam int IDX_W     = $clog2(DATA_W + 1);

  rxState_t          state;
  logic [CNT_W-1:0]  tickCnt;
  logic [IDX_W-1:0]  bitIdx;
  logic              nineFrame;
  logic [IDX_W-1:0]  lastIdx;
  logic              startOk;
  logic              atFirst, atSecond, atDecide, atLast, busy;

  assign startOk  = rxEnable && (modeSel != 2'b00) && fallEdge;
  assign lastIdx  = nineFrame ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
  assign busy     = (state != ST_IDLE) && baudTick;
  assign atFirst  = busy && (tickCnt == CNT_W'(FIRST_AT));
  assign atSecond = busy && (tickCnt == CNT_W'(SECOND_AT));
  assign atDecide = busy && (tickCnt == CNT_W'(DECIDE_AT));
  assign atLast   = busy && (tickCnt == CNT_W'(LAST_AT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      tickCnt   <= '0;
      bitIdx    <= '0;
      nineFrame <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (startOk) begin
        state     <= ST_START;
        tickCnt   <= '0;
        bitIdx    <= '0;
        nineFrame <= modeSel[1];
      end
    end else if (baudTick) begin
      tickCnt <= atLast ? '0 : tickCnt + 1'b1;
      if (atDecide && ((state == ST_START && vote) || state == ST_STOP)) begin
        state <= ST_IDLE;
      end else if (atLast) begin
        if (state == ST_START) begin
          state <= ST_DATA;
        end else if (state == ST_DATA) begin
          if (bitIdx == lastIdx) state <= ST_STOP;
          else                   bitIdx <= bitIdx + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.takeFirst  = atFirst;
    strb.takeSecond = atSecond;
    strb.shiftBit   = atDecide && (state == ST_DATA);
    strb.finish     = atDecide && (state == ST_STOP);
    strb.frameNine  = nineFrame;
  end

  // R1 and R7: no reception starts when disabled or in the unsupported setting
  a_r7_no_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !(rxEnable && modeSel != 2'b00)) |=> (state == ST_IDLE));

  // R9: the sample points of one bit never coincide
  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.takeFirst, strb.takeSecond, strb.shiftBit, strb.finish}));

endmodule

// File: rtl/serial_rx9_dp.sv
`timescale 1ns/1ps
module serial_rx9_dp
  import serial_rx9_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxPin,
  input  logic              multiDrop,
  input  logic              rxFlagClear,
  input  rxStrobes_t        strb,
  output logic              fallEdge,
  output logic              vote,
  output logic [DATA_W-1:0] rxData,
  output logic              bit9Flag,
  output logic              rxFlag
);

  logic              syncA, rxSync, rxPrev;
  logic              firstSmp, secondSmp;
  logic [DATA_W:0]   shiftReg;
  logic [DATA_W-1:0] frameByte;
  logic              ninthVal;
  logic              accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= 1'b1;
      rxSync <= 1'b1;
      rxPrev <= 1'b1;
    end else begin
      syncA  <= rxPin;
      rxSync <= syncA;
      rxPrev <= rxSync;
    end
  end

  assign fallEdge = rxPrev & ~rxSync;
  assign vote = (firstSmp & secondSmp) | (firstSmp & rxSync) | (secondSmp & rxSync);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstSmp  <= 1'b1;
      secondSmp <= 1'b1;
      shiftReg  <= '0;
    end else begin
      if (strb.takeFirst)  firstSmp  <= rxSync;
      if (strb.takeSecond) secondSmp <= rxSync;
      if (strb.shiftBit)   shiftReg  <= {vote, shiftReg[DATA_W:1]};
    end
  end

  // long frame: byte in the low bits, ninth on top; short frame: byte in the top bits
  assign frameByte = strb.frameNine ? shiftReg[DATA_W-1:0] : shiftReg[DATA_W:1];
  assign ninthVal  = strb.frameNine ? shiftReg[DATA_W] : vote;
  assign accept    = !rxFlag && (!multiDrop || ninthVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData   <= '0;
      bit9Flag <= 1'b0;
      rxFlag   <= 1'b0;
    end else if (strb.finish && accept) begin
      rxData   <= frameByte;
      bit9Flag <= ninthVal;
      rxFlag   <= 1'b1;
    end else if (rxFlagClear) begin
      rxFlag   <= 1'b0;
    end
  end

  // R4: the flag only rises at a frame end
  a_r4_flag_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFlag) |-> $past(strb.finish));

  // R5 and R6: with filtering on, only frames carrying a 1 are accepted
  a_r5_filter: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxFlag) && $past(multiDrop)) |-> bit9Flag);

  // R10: a pending frame is never overwritten
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    $past(rxFlag) |-> $stable({rxData, bit9Flag}));

  // R11: a clear pulse drops a set flag
  a_r11_clear: assert property (@(posedge clk) disable iff (!rstN)
    (rxFlag && rxFlagClear) |=> !rxFlag);

endmodule

// File: rtl/serial_rx9.sv
`timescale 1ns/1ps
module serial_rx9
  import serial_rx9_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              multiDrop,
  input  logic              rxEnable,
  input  logic              baudTick,
  input  logic              rxPin,
  input  logic              rxFlagClear,
  output logic [DATA_W-1:0] rxData,
  output logic              bit9Flag,
  output logic              rxFlag
);

  rxStrobes_t strb;
  logic       fallEdge;
  logic       vote;

  serial_rx9_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .rxEnable (rxEnable),
    .baudTick (baudTick),
    .fallEdge (fallEdge),
    .vote     (vote),
    .strb     (strb)
  );

  serial_rx9_dp #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .rxPin       (rxPin),
    .multiDrop   (multiDrop),
    .rxFlagClear (rxFlagClear),
    .strb        (strb),
    .fallEdge    (fallEdge),
    .vote        (vote),
    .rxData      (rxData),
    .bit9Flag    (bit9Flag),
    .rxFlag      (rxFlag)
  );

endmodule

// File: tb/serial_rx9_test.sv
`timescale 1ns/1ps
module serial_rx9_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeSel = 2'b01;
  logic       multiDrop = 1'b0;
  logic       rxEnable = 1'b1;
  logic       baudTick = 1'b0;
  logic       rxPin = 1'b1;
  logic       rxFlagClear = 1'b0;
  logic [7:0] rxData;
  logic       bit9Flag;
  logic       rxFlag;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  logic [7:0] expData = 8'h00;
  logic       expNine = 1'b0;
  logic       expFlag = 1'b0;

  always #2 clk = ~clk;

  serial_rx9 uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .multiDrop(multiDrop),
    .rxEnable(rxEnable), .baudTick(baudTick), .rxPin(rxPin),
    .rxFlagClear(rxFlagClear), .rxData(rxData), .bit9Flag(bit9Flag), .rxFlag(rxFlag)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic oneTick();
    repeat (7) @(negedge clk);
    baudTick = 1'b1;
    @(negedge clk);
    baudTick = 1'b0;
  endtask

  // one bit time; ticks g1 and g2 carry the inverted level
  task automatic sendBit(input logic v, input int g1, input int g2);
    for (int t = 0; t < 16; t++) begin
      rxPin = (t == g1 || t == g2) ? ~v : v;
      oneTick();
    end
  endtask

  task automatic sendFrame(input logic nine, input logic [7:0] d, input logic ninth,
                           input logic stopV, input int g1, input int g2);
    sendBit(1'b0, -1, -1);
    for (int i = 0; i < 8; i++) sendBit(d[i], (i == 3) ? g1 : -1, (i == 3) ? g2 : -1);
    if (nine) sendBit(ninth, -1, -1);
    sendBit(stopV, -1, -1);
    rxPin = 1'b1;
    oneTick();
    oneTick();
  endtask

  // model: frame with effective data d and extra bit e, given current controls
  task automatic modelFrame(input logic [7:0] d, input logic e);
    if (rxEnable && modeSel != 2'b00 && !expFlag && (!multiDrop || e)) begin
      expFlag = 1'b1;
      expData = d;
      expNine = e;
    end
  endtask

  task automatic checkAll(input string tag);
    chk({tag, " rxFlag"}, {7'd0, rxFlag}, {7'd0, expFlag});
    chk({tag, " rxData R2"}, rxData, expData);
    chk({tag, " bit9Flag R3"}, {7'd0, bit9Flag}, {7'd0, expNine});
  endtask

  task automatic clearFlag();
    @(negedge clk);
    rxFlagClear = 1'b1;
    @(negedge clk);
    rxFlagClear = 1'b0;
    expFlag = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] bytes [3];
    bytes[0] = 8'h00;
    bytes[1] = 8'hFF;
    bytes[2] = 8'hA5;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    checkAll("R12");
    repeat (3) oneTick();

    // sweep: R1 formats, R2 data, R3 extra bit, R4/R5/R6 filtering
    for (int m = 1; m < 4; m++) begin
      for (int md = 0; md < 2; md++) begin
        for (int v = 0; v < 2; v++) begin
          for (int b = 0; b < 3; b++) begin
            logic nine;
            logic [7:0] d;
            string tag;
            nine = (m != 1);
            d = bytes[b] ^ 8'(m * 37 + v * 11);
            modeSel = 2'(m);
            multiDrop = md[0];
            if (md == 1 && v == 0) tag = nine ? "R5" : "R6";
            else tag = "R4 R1";
            if (nine) sendFrame(1'b1, d, v[0], 1'b1, -1, -1);
            else      sendFrame(1'b0, d, 1'b0, v[0], -1, -1);
            modelFrame(d, v[0]);
            checkAll(tag);
            if (rxFlag) clearFlag();
          end
        end
      end
    end

    // R10: second frame while flag set is discarded
    modeSel = 2'b10;
    multiDrop = 1'b0;
    sendFrame(1'b1, 8'h5A, 1'b1, 1'b1, -1, -1);
    modelFrame(8'h5A, 1'b1);
    checkAll("R10 first");
    sendFrame(1'b1, 8'hC3, 1'b0, 1'b1, -1, -1);
    modelFrame(8'hC3, 1'b0);
    checkAll("R10 held");

    // R11: clear pulse
    @(negedge clk);
    rxFlagClear = 1'b1;
    @(negedge clk);
    rxFlagClear = 1'b0;
    chk("R11 flag after clear", {7'd0, rxFlag}, 8'd0);
    expFlag = 1'b0;

    // R7: receiver disabled
    rxEnable = 1'b0;
    sendFrame(1'b1, 8'h81, 1'b1, 1'b1, -1, -1);
    modelFrame(8'h81, 1'b1);
    checkAll("R7");
    rxEnable = 1'b1;

    // R1: setting 00 starts nothing
    modeSel = 2'b00;
    sendFrame(1'b0, 8'h42, 1'b0, 1'b1, -1, -1);
    modelFrame(8'h42, 1'b1);
    checkAll("R1 mode00");

    // R8: false start, then a normal frame
    modeSel = 2'b01;
    for (int t = 0; t < 16; t++) begin
      rxPin = (t < 6) ? 1'b0 : 1'b1;
      oneTick();
    end
    repeat (2) oneTick();
    checkAll("R8 false start");
    sendFrame(1'b0, 8'h6E, 1'b0, 1'b1, -1, -1);
    modelFrame(8'h6E, 1'b1);
    checkAll("R8 recovery");
    clearFlag();

    // R9: one bad sample at tick 8 is outvoted; two at ticks 8 and 9 win
    sendFrame(1'b0, 8'h0F, 1'b0, 1'b1, 8, -1);
    modelFrame(8'h0F, 1'b1);
    checkAll("R9 single glitch");
    clearFlag();
    sendFrame(1'b0, 8'h0F, 1'b0, 1'b1, 8, 9);
    modelFrame(8'h07, 1'b1);
    checkAll("R9 double glitch");
    clearFlag();
    sendFrame(1'b0, 8'hF0, 1'b0, 1'b1, 7, -1);
    modelFrame(8'hF0, 1'b1);
    checkAll("R9 glitch tick7");
    clearFlag();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule